// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of a bank of 16-bit counter channels. The channels are arranged in groups of three, and the groups are linked in a ring. Each channel holds a 3-bit clock-select code and a 3-bit gate-select code, both written over a simple register bus. The router picks one count-enable pulse and one gate level for each channel from these sources:

- the channel's own pins;
- a group-wide clock pin;
- five internal timebases;
- the outputs of neighbouring channels, including channels in the preceding group.

Everything runs on one 10 MHz reference clock. The internal timebases come from a decade prescaler chain as single-cycle enable pulses, not as derived clocks.

Each channel owns a dedicated clock pin and a dedicated gate pin.

- A pin is an input only when its code selects that pin.
- For any other code, the pin's output enable is raised and the pin carries the resolved count pulse or gate level.

The counters are a minimal stand-in for real counter cores. Each is a down-counter with a reload register. Its OUT signal toggles each time an enabled count pulse finds the counter at zero.

Top module: `cgr_router`

## Requirements
- R1: Clock code 0 counts synchronised rising edges of the channel's own clock pin. Each edge yields exactly one count pulse.
- R2: Clock codes 1 to 5 select the internal timebases. Their periods are 1, 10, 100, 1000 and 10000 reference cycles (10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz). Each timebase pulse lasts one cycle.
- R3: Clock code 6 counts rising edges of the preceding channel's OUT. For channel 1 or 2 that is channel n-1 of the same group. For channel 0 it is channel 2 of the preceding group, and the last group precedes group 0.
- R4: Clock code 7 counts synchronised rising edges of the group's shared clock pin. The pin is seen by all three channels of that group and by no other group.
- R5: A channel's clock-pin output enable is high exactly when its clock code is not 0.
- R6: Gate code 0 enables counting, code 1 disables it, and code 2 follows the synchronised level of the channel's gate pin.
- R7: Gate code 3 uses the inverse of a partner's OUT. For channel 2 the partner is channel 0 of the same group. For channel 0 or 1 it is channel n+1 of the preceding group.
- R8: Gate codes 4 to 7 are stored and read back unchanged, but they disable counting.
- R9: A channel's gate-pin output enable is high exactly when its gate code is not 2.
- R10: The register address is {channel, sel[1:0]}: sel 0 is the clock code, sel 1 the gate code, sel 2 the reload value. Read data appears one cycle after rd_en. A clock-code read also reports the timebase period in ns: 100, 1000, 10000, 100000 or 1000000 for codes 1 to 5, and 0 otherwise.
- R11: After reset every clock code and gate code is 0, every OUT is 0, every clock-pin enable is 0 and every gate-pin enable is 1.
- R12: With reload value R, OUT toggles once every R+1 enabled count pulses. ext_clk_o repeats each selected count pulse one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | {channel, sel[1:0]} |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| rd_period_ns | output | 20 | Timebase period reported with clock-code reads |
| ext_clk_i | input | NCH | Per-channel clock pins (input side) |
| ext_clk_o | output | NCH | Per-channel clock pins (output side): the selected count pulse |
| ext_clk_oe | output | NCH | Per-channel clock-pin output enables |
| ext_gat_i | input | NCH | Per-channel gate pins (input side) |
| ext_gat_o | output | NCH | Per-channel gate pins (output side): the resolved gate |
| ext_gat_oe | output | NCH | Per-channel gate-pin output enables |
| grp_clk_i | input | NUM_GROUPS | Shared clock pin of each group |
| chan_out | output | NCH | OUT of each counter channel |

## Verification
Two paths are the hardest to reach from the ports: the inverted-output gate and the cross-group ring. Each needs a neighbour's OUT to be held at a known level while the channel under test runs.

The bench handles this by selecting the partner's own pin as its clock and leaving that pin idle, which freezes the partner's OUT. It then reads that level at chan_out. A single pin pulse flips the partner, so both gate polarities are covered. The ring links are driven by setting the source channel to the 10 MHz timebase with a reload of zero. The bench then counts the pulses that reach the next channel over an exact window.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  localparam int CPG    = 3;   // channels per group
  localparam int NUM_TB = 5;   // internal timebases
  localparam int DIV    = 10;  // decade prescaler ratio

  typedef enum logic [2:0] {
    CK_PIN = 3'd0, CK_TB0 = 3'd1, CK_TB1 = 3'd2, CK_TB2 = 3'd3,
    CK_TB3 = 3'd4, CK_TB4 = 3'd5, CK_PREV = 3'd6, CK_GRP = 3'd7
  } clk_code_t;

  typedef enum logic [2:0] {
    GT_HIGH = 3'd0, GT_LOW = 3'd1, GT_PIN = 3'd2, GT_NOUT = 3'd3
  } gate_code_t;

  // Period in ns of an internal timebase; 0 for any other clock code.
  function automatic logic [19:0] tb_period_ns(logic [2:0] code);
    logic [19:0] p;
    p = '0;
    if (code >= 3'd1 && code <= 3'd5) begin
      p = 20'd100;
      for (int i = 1; i < NUM_TB; i++)
        if (3'(i) < code) p = 20'(p * 20'd10);
    end
    return p;
  endfunction
endpackage

// File: rtl/cgr_prescaler.sv
module cgr_prescaler #(
  parameter int NTB   = 5,
  parameter int RATIO = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NTB-1:0] tb
);
  localparam int DW = $clog2(RATIO);
  localparam logic [DW-1:0] TOP = DW'(RATIO - 1);

  assign tb[0] = 1'b1;

  genvar k;
  generate
    for (k = 1; k < NTB; k++) begin : g_stage
      logic [DW-1:0] dig_q;
      assign tb[k] = tb[k-1] && (dig_q == TOP);
      always_ff @(posedge clk) begin
        if (rst)           dig_q <= '0;
        else if (tb[k-1])  dig_q <= (dig_q == TOP) ? '0 : dig_q + 1'b1;
      end
      assert_digit_range_R2: assert property (@(posedge clk) disable iff (rst)
        dig_q <= TOP);
      assert_tb_single_R2: assert property (@(posedge clk) disable iff (rst)
        tb[k] |=> !tb[k]);
    end
  endgenerate
endmodule

// File: rtl/cgr_edge_sync.sv
module cgr_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic s1_q, s2_q, s3_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= din; s2_q <= s1_q; s3_q <= s2_q;
    end
  end
  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/cgr_channel.sv
module cgr_channel
  import cgr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        clk_sel,
  input  logic [2:0]        gate_sel,
  input  logic [CNT_W-1:0]  reload,
  input  logic [NUM_TB-1:0] tb,
  input  logic              clk_pin_i,
  input  logic              gat_pin_i,
  input  logic              grp_rise,
  input  logic              prev_rise,
  input  logic              partner_out,
  output logic              out_q,
  output logic              out_rise,
  output logic              clk_o,
  output logic              clk_oe,
  output logic              gat_o,
  output logic              gat_oe
);
  logic pin_rise, pin_lvl_unused, gat_lvl, gat_rise_unused;
  logic tick, gate_en, out_d;
  logic [CNT_W-1:0] cnt_q;

  cgr_edge_sync u_ck (.clk(clk), .rst(rst), .din(clk_pin_i),
                      .lvl(pin_lvl_unused), .rise(pin_rise));
  cgr_edge_sync u_gt (.clk(clk), .rst(rst), .din(gat_pin_i),
                      .lvl(gat_lvl), .rise(gat_rise_unused));

  always_comb begin
    case (clk_code_t'(clk_sel))
      CK_PIN:  tick = pin_rise;
      CK_TB0:  tick = tb[0];
      CK_TB1:  tick = tb[1];
      CK_TB2:  tick = tb[2];
      CK_TB3:  tick = tb[3];
      CK_TB4:  tick = tb[4];
      CK_PREV: tick = prev_rise;
      default: tick = grp_rise;
    endcase
  end

  always_comb begin
    case (gate_sel)
      3'd0:    gate_en = 1'b1;
      3'd2:    gate_en = gat_lvl;
      3'd3:    gate_en = ~partner_out;
      default: gate_en = 1'b0;   // code 1 and reserved codes
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0; out_q <= 1'b0; out_d <= 1'b0;
      clk_o <= 1'b0; clk_oe <= 1'b0; gat_o <= 1'b0; gat_oe <= 1'b1;
    end else begin
      if (tick && gate_en) begin
        if (cnt_q == '0) begin
          cnt_q <= reload;
          out_q <= ~out_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      out_d  <= out_q;
      clk_o  <= tick;
      clk_oe <= (clk_sel != CK_PIN);
      gat_o  <= gate_en;
      gat_oe <= (gate_sel != GT_PIN);
    end
  end

  assign out_rise = out_q & ~out_d;

  assert_gate_low_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (gate_sel == 3'd1) |=> $stable(out_q));
  assert_reserved_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    gate_sel[2] |=> $stable(out_q));
  assert_toggle_at_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(out_q));
endmodule

// File: rtl/cgr_router.sv
module cgr_router
  import cgr_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = $clog2(NUM_GROUPS * 3) + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          wdata,
  output logic [CNT_W-1:0]          rdata,
  output logic [19:0]               rd_period_ns,
  input  logic [NUM_GROUPS*3-1:0]   ext_clk_i,
  output logic [NUM_GROUPS*3-1:0]   ext_clk_o,
  output logic [NUM_GROUPS*3-1:0]   ext_clk_oe,
  input  logic [NUM_GROUPS*3-1:0]   ext_gat_i,
  output logic [NUM_GROUPS*3-1:0]   ext_gat_o,
  output logic [NUM_GROUPS*3-1:0]   ext_gat_oe,
  input  logic [NUM_GROUPS-1:0]     grp_clk_i,
  output logic [NUM_GROUPS*3-1:0]   chan_out
);
  localparam int NCH  = NUM_GROUPS * CPG;
  localparam int CH_W = ADDR_W - 2;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  logic [2:0]       clk_sel  [NCH];
  logic [2:0]       gate_sel [NCH];
  logic [CNT_W-1:0] reload   [NCH];
  logic [NUM_TB-1:0] tb;
  logic [NUM_GROUPS-1:0] grp_rise, grp_lvl_unused;
  logic [NCH-1:0] rise_v;

  logic [CH_W-1:0] a_ch;
  logic [1:0]      a_sel;
  logic            a_ok;
  assign a_ch  = addr[ADDR_W-1:2];
  assign a_sel = addr[1:0];
  assign a_ok  = (a_ch <= LAST_CH);

  cgr_prescaler #(.NTB(NUM_TB), .RATIO(DIV)) u_pre (.clk(clk), .rst(rst), .tb(tb));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        clk_sel[i] <= '0; gate_sel[i] <= '0; reload[i] <= '0;
      end
    end else if (wr_en && a_ok) begin
      case (a_sel)
        2'd0: clk_sel[a_ch]  <= wdata[2:0];
        2'd1: gate_sel[a_ch] <= wdata[2:0];
        2'd2: reload[a_ch]   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0; rd_period_ns <= '0;
    end else if (rd_en) begin
      rdata <= '0; rd_period_ns <= '0;
      if (a_ok) begin
        case (a_sel)
          2'd0: begin
            rdata        <= CNT_W'(clk_sel[a_ch]);
            rd_period_ns <= tb_period_ns(clk_sel[a_ch]);
          end
          2'd1: rdata <= CNT_W'(gate_sel[a_ch]);
          2'd2: rdata <= reload[a_ch];
          default: ;
        endcase
      end
    end
  end

  genvar g, c;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int PG = (g + NUM_GROUPS - 1) % NUM_GROUPS;
      cgr_edge_sync u_gsync (.clk(clk), .rst(rst), .din(grp_clk_i[g]),
                             .lvl(grp_lvl_unused[g]), .rise(grp_rise[g]));
      for (c = 0; c < CPG; c++) begin : g_ch
        localparam int IDX  = g * CPG + c;
        localparam int PREV = (c > 0) ? IDX - 1 : PG * CPG + CPG - 1;
        localparam int PART = (c == CPG - 1) ? g * CPG : PG * CPG + c + 1;
        cgr_channel #(.CNT_W(CNT_W)) u_ch (
          .clk(clk), .rst(rst),
          .clk_sel(clk_sel[IDX]), .gate_sel(gate_sel[IDX]), .reload(reload[IDX]),
          .tb(tb), .clk_pin_i(ext_clk_i[IDX]), .gat_pin_i(ext_gat_i[IDX]),
          .grp_rise(grp_rise[g]), .prev_rise(rise_v[PREV]),
          .partner_out(chan_out[PART]),
          .out_q(chan_out[IDX]), .out_rise(rise_v[IDX]),
          .clk_o(ext_clk_o[IDX]), .clk_oe(ext_clk_oe[IDX]),
          .gat_o(ext_gat_o[IDX]), .gat_oe(ext_gat_oe[IDX]));
      end
    end
  endgenerate

  assert_period_after_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_period_ns != '0) |-> ($past(rd_en) || $stable(rd_period_ns)));
  assert_period_legal_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_period_ns == '0) || (rdata >= CNT_W'(1) && rdata <= CNT_W'(5)));
endmodule

// File: tb/cgr_router_test.sv
module cgr_router_test;
  localparam int NG  = 2;
  localparam int NCH = NG * 3;
  localparam int AW  = $clog2(NCH) + 2;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [19:0] rd_period_ns;
  logic [NCH-1:0] ext_clk_i = '0, ext_gat_i = '0;
  logic [NCH-1:0] ext_clk_o, ext_clk_oe, ext_gat_o, ext_gat_oe, chan_out;
  logic [NG-1:0] grp_clk_i = '0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cgr_router #(.NUM_GROUPS(NG), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_period_ns(rd_period_ns),
    .ext_clk_i(ext_clk_i), .ext_clk_o(ext_clk_o), .ext_clk_oe(ext_clk_oe),
    .ext_gat_i(ext_gat_i), .ext_gat_o(ext_gat_o), .ext_gat_oe(ext_gat_oe),
    .grp_clk_i(grp_clk_i), .chan_out(chan_out));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int sel, int val);
    @(negedge clk);
    addr = AW'(ch * 4 + sel); wdata = 16'(val); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int ch, int sel);
    @(negedge clk);
    addr = AW'(ch * 4 + sel); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulses(int ch, int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (ext_clk_o[ch]) n++;
    end
  endtask

  task automatic count_toggles(int ch, int len, output int n);
    logic p;
    n = 0; p = chan_out[ch];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (chan_out[ch] != p) n++;
      p = chan_out[ch];
    end
  endtask

  function automatic int period_ns(int code);
    int p;
    p = 0;
    if (code >= 1 && code <= 5) begin
      p = 100;
      for (int i = 1; i < code; i++) p = p * 10;
    end
    return p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, v;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R11: reset state
    chk("R11 out", int'(chan_out), 0);
    chk("R11 clk_oe", int'(ext_clk_oe), 0);
    chk("R11 gat_oe", int'(ext_gat_oe), (1 << NCH) - 1);
    for (int ch = 0; ch < NCH; ch++) begin
      rd(ch, 0); chk("R11 clk code", int'(rdata), 0);
      rd(ch, 1); chk("R11 gate code", int'(rdata), 0);
    end

    // R5 / R10: clock code sweep on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int code = 0; code < 8; code++) begin
        wr(ch, 0, code); idle(1);
        chk("R5 clk_oe", int'(ext_clk_oe[ch]), (code != 0) ? 1 : 0);
        rd(ch, 0);
        chk("R10 clk code", int'(rdata), code);
        chk("R10 period", int'(rd_period_ns), period_ns(code));
      end
      wr(ch, 0, 0);
    end

    // R9 / R8: gate code sweep, reserved codes read back
    for (int ch = 0; ch < NCH; ch++) begin
      for (int code = 0; code < 8; code++) begin
        wr(ch, 1, code); idle(1);
        chk("R9 gat_oe", int'(ext_gat_oe[ch]), (code != 2) ? 1 : 0);
        rd(ch, 1);
        chk("R8 gate readback", int'(rdata), code);
      end
      wr(ch, 1, 0);
    end

    // R2: internal timebases on channel 0
    begin
      int lens [5] = '{100, 1000, 10000, 10000, 20000};
      for (int code = 1; code <= 5; code++) begin
        int per;
        per = period_ns(code) / 100;
        wr(0, 0, code); idle(5);
        count_pulses(0, lens[code-1], n);
        chk("R2 timebase pulses", n, lens[code-1] / per);
      end
    end

    // R12: reload 3 -> toggle every 4 pulses at 10 MHz
    wr(0, 0, 1); wr(0, 2, 3); idle(10);
    count_toggles(0, 80, n);
    chk("R12 reload toggles", n, 20);
    rd(0, 2); chk("R12 reload readback", int'(rdata), 3);
    wr(0, 2, 0); idle(10);
    count_toggles(0, 40, n);
    chk("R12 reload0 toggles", n, 40);

    // R1: dedicated pin clock on channel 1
    n = 0; v = 0;
    for (int i = 0; i < 7 * 4 + 12; i++) begin
      @(negedge clk);
      ext_clk_i[1] = (i < 28) && ((i % 4) >= 2);
      if (ext_clk_o[1]) n++;
      if (ext_clk_o[2]) v++;
    end
    chk("R1 pin edges", n, 7);
    chk("R1 neighbour untouched", v, 0);

    // R4: shared group clock, group 1
    wr(0, 0, 0);
    for (int ch = 3; ch < 6; ch++) wr(ch, 0, 7);
    wr(2, 0, 7);
    begin
      int c3, c4, c5, c0, c2;
      c3 = 0; c4 = 0; c5 = 0; c0 = 0; c2 = 0;
      for (int i = 0; i < 5 * 4 + 12; i++) begin
        @(negedge clk);
        grp_clk_i[1] = (i < 20) && ((i % 4) >= 2);
        if (ext_clk_o[3]) c3++;
        if (ext_clk_o[4]) c4++;
        if (ext_clk_o[5]) c5++;
        if (ext_clk_o[0]) c0++;
        if (ext_clk_o[2]) c2++;
      end
      chk("R4 grp ch3", c3, 5); chk("R4 grp ch4", c4, 5); chk("R4 grp ch5", c5, 5);
      chk("R4 other group", c2, 0); chk("R4 pin code", c0, 0);
    end
    for (int ch = 2; ch < 6; ch++) wr(ch, 0, 0);

    // R3: preceding channel within group and across the ring
    wr(0, 0, 1); wr(1, 0, 6); idle(10);
    count_pulses(1, 200, n); chk("R3 ch1<-ch0", n, 100);
    wr(1, 0, 0); wr(2, 0, 1); wr(3, 0, 6); idle(10);
    count_pulses(3, 200, n); chk("R3 grp1 ch0<-grp0 ch2", n, 100);
    wr(2, 0, 0); wr(3, 0, 0); wr(5, 0, 1); wr(0, 0, 6); idle(10);
    count_pulses(0, 200, n); chk("R3 ring ch0<-ch5", n, 100);
    wr(5, 0, 0);

    // R6 / R8: gate codes on channel 0 at 10 MHz
    wr(0, 0, 1);
    wr(0, 1, 1); idle(5);
    count_toggles(0, 20, n); chk("R6 gate low", n, 0);
    chk("R6 gat_o low", int'(ext_gat_o[0]), 0);
    wr(0, 1, 0); idle(5);
    count_toggles(0, 20, n); chk("R6 gate high", n, 20);
    chk("R6 gat_o high", int'(ext_gat_o[0]), 1);
    ext_gat_i[0] = 1'b0; wr(0, 1, 2); idle(5);
    count_toggles(0, 20, n); chk("R6 gate pin low", n, 0);
    ext_gat_i[0] = 1'b1; idle(5);
    count_toggles(0, 20, n); chk("R6 gate pin high", n, 20);
    for (int code = 4; code < 8; code++) begin
      wr(0, 1, code); idle(5);
      count_toggles(0, 20, n); chk("R8 reserved gate", n, 0);
    end

    // R7: inverted partner output, same group (ch2 <- ch0)
    wr(0, 1, 0); wr(0, 0, 0); idle(5);
    wr(2, 0, 1); wr(2, 1, 3); idle(5);
    for (int k = 0; k < 2; k++) begin
      v = int'(chan_out[0]);
      count_toggles(2, 20, n); chk("R7 ch2 partner ch0", n, v ? 0 : 20);
      @(negedge clk); ext_clk_i[0] = 1'b1;
      @(negedge clk); ext_clk_i[0] = 1'b0;
      idle(8);
      chk("R7 partner flipped", int'(chan_out[0]), v ? 0 : 1);
    end
    wr(2, 1, 0); wr(2, 0, 0);

    // R7: across groups (ch3 <- group 0 ch1)
    wr(1, 0, 0); idle(5);
    wr(3, 0, 1); wr(3, 1, 3); idle(5);
    for (int k = 0; k < 2; k++) begin
      v = int'(chan_out[1]);
      count_toggles(3, 20, n); chk("R7 ch3 partner ch1", n, v ? 0 : 20);
      @(negedge clk); ext_clk_i[1] = 1'b1;
      @(negedge clk); ext_clk_i[1] = 1'b0;
      idle(8);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule